// File: doc/BRIEF.md
# Serial Binary Remainder Calculator

This block reads an unsigned binary number one bit at a time, most significant bit first. After each accepted bit it reports the remainder, modulo a small fixed divisor, of the number made up of the bits seen so far. Each residue class has its own state. An accepted bit moves the machine from residue r to (2*r + bit) mod N. A synchronous clear starts a new number from residue 0.

One parameter picks one of two builds. With a divisor of 3, the block is a Moore machine with three states. Its remainder is decoded from the present state alone, so the remainder of a bit appears in the cycle after that bit. With a divisor of 5, the block is a Mealy machine with five states. Its remainder is a function of the present state and the incoming bit. In that build the new remainder shows in the same cycle as the bit, and the state register takes that value on the next clock edge. The valid flag shows that the remainder covers at least one bit since the last clear.

Top module: `serial_residue`

## Requirements
- R1: In the cycle after a clear, both builds output rem_out = 0 and rem_valid = 0.
- R2: In the divisor-3 build, after a cycle with bit_valid = 1 and clear = 0, rem_out in the next cycle equals (2*r + bit_in) mod 3, where r is the value rem_out had in the cycle of the bit.
- R3: The divisor-3 build has three states, whose residues are 0, 1 and 2, and rem_out never exceeds 2 once the block has been cleared.
- R4: In the divisor-5 build, during a cycle with bit_valid = 1 and clear = 0, rem_out equals (2*r + bit_in) mod 5, where r is the stored residue. On the following clock edge the stored residue takes that value.
- R5: While bit_valid = 0 and clear = 0, the state holds and rem_out does not change in either build, whatever bit_in does.
- R6: When clear and a valid bit arrive in the same cycle, the clear wins: in the next cycle rem_out = 0 and rem_valid = 0 in both builds.
- R7: rem_valid is low from a clear until the first accepted bit, and then stays high until the next clear. It rises in the cycle after that bit in the divisor-3 build, and in the cycle of that bit in the divisor-5 build.
- R8: When the numbers 3, 4, 5, 6, 76 and 101 are fed in serially after a clear, the final remainders are 0, 1, 2, 0, 1, 2 modulo 3 and 3, 4, 0, 1, 1, 1 modulo 5.
- R9: In the divisor-5 build, during any cycle with clear = 1, rem_out = 0 and rem_valid = 0, even if bit_valid = 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear to residue 0; has priority over bit_valid |
| bit_valid | input | 1 | High when bit_in carries the next bit of the number |
| bit_in | input | 1 | Serial data bit, most significant bit first |
| rem_out | output | REM_W (3) | Remainder of the bits accepted so far, 0 to DIVISOR-1 |
| rem_valid | output | 1 | High once at least one bit has been accepted since clear |

## Verification
A wrong transition leaves the block in the wrong residue class, and the error does not go away: every later remainder is wrong until the next clear. The divisor-3 build shows this at rem_out one cycle after the faulty bit. The divisor-5 build shows it in the same cycle, through its combinational output. The bench therefore compares every intermediate prefix remainder rather than only the final one, so a wrong transition is caught at the bit that caused it. A hold or clear-priority fault appears as a rem_out change in the first idle or clearing cycle.

// File: rtl/serial_residue_pkg.sv
package serial_residue_pkg;

    // Residue states of the divisor-3 machine; the code equals the residue
    typedef enum logic [1:0] {
        M3_ZERO = 2'd0,
        M3_ONE  = 2'd1,
        M3_TWO  = 2'd2
    } mod3_state_e;

    // Residue states of the divisor-5 machine; the code equals the residue
    typedef enum logic [2:0] {
        M5_ZERO  = 3'd0,
        M5_ONE   = 3'd1,
        M5_TWO   = 3'd2,
        M5_THREE = 3'd3,
        M5_FOUR  = 3'd4
    } mod5_state_e;

    typedef struct packed {
        mod3_state_e state;
        logic        seen;
    } mod3_regs_t;

    typedef struct packed {
        mod5_state_e state;
        logic        seen;
    } mod5_regs_t;

endpackage

// File: rtl/residue_moore.sv
module residue_moore
    import serial_residue_pkg::*;
#(
    parameter int REM_W = 3
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [REM_W-1:0] rem_out,
    output logic             rem_valid
);

    mod3_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clear) begin
            regs_d.state = M3_ZERO;
            regs_d.seen  = 1'b0;
        end else if (bit_valid) begin
            regs_d.seen = 1'b1;
            case (regs_q.state)
                M3_ZERO: regs_d.state = bit_in ? M3_ONE  : M3_ZERO;
                M3_ONE:  regs_d.state = bit_in ? M3_ZERO : M3_TWO;
                M3_TWO:  regs_d.state = bit_in ? M3_TWO  : M3_ONE;
                default: regs_d.state = M3_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // Output decoded from the present state only
    always_comb begin
        case (regs_q.state)
            M3_ONE:  rem_out = REM_W'(1);
            M3_TWO:  rem_out = REM_W'(2);
            default: rem_out = REM_W'(0);
        endcase
        rem_valid = regs_q.seen;
    end

    // R2
    moore_step_chk: assert property (@(posedge clk) disable iff (clear)
        (bit_valid && !clear) |=>
            (int'(rem_out) == (2 * int'($past(rem_out)) + int'($past(bit_in))) % 3));

    // R3
    moore_range_chk: assert property (@(posedge clk) disable iff (clear)
        int'(rem_out) <= 2);

    // R5
    moore_hold_chk: assert property (@(posedge clk) disable iff (clear)
        (!bit_valid && !clear) |=> ($stable(rem_out) && $stable(rem_valid)));

    // R6
    moore_clear_chk: assert property (@(posedge clk)
        clear |=> (rem_out == '0 && !rem_valid));

    // R7
    moore_valid_chk: assert property (@(posedge clk) disable iff (clear)
        (bit_valid && !clear) |=> rem_valid);

endmodule

// File: rtl/residue_mealy.sv
module residue_mealy
    import serial_residue_pkg::*;
#(
    parameter int REM_W = 3
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [REM_W-1:0] rem_out,
    output logic             rem_valid
);

    mod5_regs_t  regs_d, regs_q;
    mod5_state_e step;

    // Residue after appending bit_in to the stored residue
    always_comb begin
        case (regs_q.state)
            M5_ZERO:  step = bit_in ? M5_ONE   : M5_ZERO;
            M5_ONE:   step = bit_in ? M5_THREE : M5_TWO;
            M5_TWO:   step = bit_in ? M5_ZERO  : M5_FOUR;
            M5_THREE: step = bit_in ? M5_TWO   : M5_ONE;
            M5_FOUR:  step = bit_in ? M5_FOUR  : M5_THREE;
            default:  step = M5_ZERO;
        endcase
    end

    always_comb begin
        regs_d = regs_q;
        if (clear) begin
            regs_d.state = M5_ZERO;
            regs_d.seen  = 1'b0;
        end else if (bit_valid) begin
            regs_d.state = step;
            regs_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // Output depends on the present state and the incoming bit
    always_comb begin
        if (clear) begin
            rem_out   = '0;
            rem_valid = 1'b0;
        end else if (bit_valid) begin
            rem_out   = REM_W'(step);
            rem_valid = 1'b1;
        end else begin
            rem_out   = REM_W'(regs_q.state);
            rem_valid = regs_q.seen;
        end
    end

    // R4
    mealy_out_chk: assert property (@(posedge clk) disable iff (clear)
        (bit_valid && !clear) |->
            (int'(rem_out) == (2 * int'(regs_q.state) + int'(bit_in)) % 5));

    // R4
    mealy_commit_chk: assert property (@(posedge clk) disable iff (clear)
        (bit_valid && !clear) |=> (int'(regs_q.state) == int'($past(rem_out))));

    // R5
    mealy_hold_chk: assert property (@(posedge clk) disable iff (clear)
        (!bit_valid && !clear) |=> $stable(regs_q));

    // R9
    mealy_clear_chk: assert property (@(posedge clk)
        clear |-> (rem_out == '0 && !rem_valid));

    // R6
    mealy_prio_chk: assert property (@(posedge clk)
        clear |=> (regs_q.state == M5_ZERO && !regs_q.seen));

endmodule

// File: rtl/serial_residue.sv
module serial_residue #(
    parameter int DIVISOR = 3,
    parameter int REM_W   = 3
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [REM_W-1:0] rem_out,
    output logic             rem_valid
);

    generate
        if (DIVISOR == 5) begin : g_mealy
            residue_mealy #(.REM_W(REM_W)) u_core (
                .clk       (clk),
                .clear     (clear),
                .bit_valid (bit_valid),
                .bit_in    (bit_in),
                .rem_out   (rem_out),
                .rem_valid (rem_valid)
            );
        end else begin : g_moore
            residue_moore #(.REM_W(REM_W)) u_core (
                .clk       (clk),
                .clear     (clear),
                .bit_valid (bit_valid),
                .bit_in    (bit_in),
                .rem_out   (rem_out),
                .rem_valid (rem_valid)
            );
        end
    endgenerate

endmodule

// File: tb/serial_residue_tb.sv
module serial_residue_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       clear     = 1'b1;
    logic       bit_valid = 1'b0;
    logic       bit_in    = 1'b0;
    logic [2:0] r3, r5;
    logic       v3, v5;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    serial_residue #(.DIVISOR(3), .REM_W(3)) u_dut (
        .clk(clk), .clear(clear), .bit_valid(bit_valid), .bit_in(bit_in),
        .rem_out(r3), .rem_valid(v3)
    );

    serial_residue #(.DIVISOR(5), .REM_W(3)) u_dut_m5 (
        .clk(clk), .clear(clear), .bit_valid(bit_valid), .bit_in(bit_in),
        .rem_out(r5), .rem_valid(v5)
    );

    localparam int NVEC = 9;
    localparam int VEC_VAL [NVEC] = '{3, 4, 5, 6, 76, 101, 0, 255, 1000};
    localparam int VEC_W   [NVEC] = '{4, 3, 3, 3, 7, 7, 1, 8, 10};

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        bit_valid = 1'b0;
        #1;
        check("R9 mealy out in clear", 8'(r5), 8'd0);
        check("R9 mealy valid in clear", 8'(v5), 8'd0);
        @(negedge clk);
        clear = 1'b0;
        #1;
        check("R1 moore out", 8'(r3), 8'd0);
        check("R1 mealy out", 8'(r5), 8'd0);
        check("R1 moore valid", 8'(v3), 8'd0);
        check("R1 mealy valid", 8'(v5), 8'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);

        // Vector walk: every prefix remainder and the final remainder
        for (int v = 0; v < NVEC; v++) begin
            do_clear();
            for (int i = VEC_W[v] - 1; i >= 0; i--) begin
                int pre;
                pre = VEC_VAL[v] >> i;
                bit_valid = 1'b1;
                bit_in = pre[0];
                #1;
                check("R4 mealy same-cycle", 8'(r5), 8'(pre % 5));
                @(negedge clk);
                check("R2 moore next-cycle", 8'(r3), 8'(pre % 3));
                check("R3 moore range", 8'(r3 <= 3'd2), 8'd1);
            end
            bit_valid = 1'b0;
            #1;
            check("R8 final mod 3", 8'(r3), 8'(VEC_VAL[v] % 3));
            check("R8 final mod 5", 8'(r5), 8'(VEC_VAL[v] % 5));
            check("R7 moore valid held", 8'(v3), 8'd1);
            check("R7 mealy valid held", 8'(v5), 8'd1);
        end

        // R7: valid flag timing on the first bit
        do_clear();
        bit_valid = 1'b1;
        bit_in = 1'b1;
        #1;
        check("R7 mealy valid same cycle", 8'(v5), 8'd1);
        check("R7 moore valid not yet", 8'(v3), 8'd0);
        @(negedge clk);
        check("R7 moore valid next cycle", 8'(v3), 8'd1);
        check("R2 moore after 1", 8'(r3), 8'd1);

        // R5: idle cycles with bit_in toggling
        bit_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            bit_in = ~bit_in;
            #1;
            check("R5 moore hold", 8'(r3), 8'd1);
            check("R5 mealy hold", 8'(r5), 8'd1);
            @(negedge clk);
        end

        // Move to residue 2, then clear together with a valid bit
        bit_valid = 1'b1;
        bit_in = 1'b0;
        @(negedge clk);
        check("R2 moore after 10", 8'(r3), 8'd2);
        clear = 1'b1;
        bit_valid = 1'b1;
        bit_in = 1'b1;
        #1;
        check("R9 mealy clear beats bit", 8'(r5), 8'd0);
        check("R9 mealy valid low", 8'(v5), 8'd0);
        @(negedge clk);
        clear = 1'b0;
        bit_valid = 1'b0;
        #1;
        check("R6 moore cleared", 8'(r3), 8'd0);
        check("R6 mealy cleared", 8'(r5), 8'd0);
        check("R6 moore valid low", 8'(v3), 8'd0);
        check("R6 mealy valid low", 8'(v5), 8'd0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule